// File: doc/BRIEF.md
# Legacy Memory Attribute and SMRAM Decoder

This block steers every access that falls below the 1 MB boundary. It takes a 20-bit physical address and the access direction. It then reports whether the access is served from system DRAM, is passed on to the PCI bus, or is a write that has to be dropped because the target region is marked read-only. The expansion-ROM segments (0xC0000 to 0xEFFFF, twelve 16 KB pieces) and the 64 KB BIOS segment (0xF0000 to 0xFFFFF) each carry a 2-bit attribute taken from a small bank of byte registers. The 128 KB graphics/SMRAM window (0xA0000 to 0xBFFFF) is governed by a separate control byte together with the processor's system-management-mode indication.

Registers are loaded through a byte-wide write port addressed by an 8-bit offset. Decoding is purely combinational from the register state, the SMM input and the access inputs, so a register write is in force for the access presented on the following cycle. A constant output reports the installed memory size in 8 MB units, which is fixed at build time.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset all attribute bytes are 0x00 and the window control byte is 0x02, so every ROM/BIOS segment and the window forward to PCI when SMM is inactive.
- R2: The attribute bytes sit at offsets 0x59 to 0x5F. The BIOS segment 0xF0000 to 0xFFFFF uses bits [5:4] of offset 0x59.
- R3: ROM segment i (0 to 11) covers 0xC0000 + i*0x4000 for 0x4000 bytes. It uses offset 0x5A + i/2: bits [1:0] when i is even and bits [5:4] when i is odd.
- R4: Attribute value 3 selects DRAM for both reads and writes, with no write block.
- R5: Attribute value 1 selects DRAM. A write to such a region also raises wr_blocked_o, and a read does not.
- R6: Attribute values 0 and 2 forward both reads and writes to PCI, with no write block.
- R7: The window control byte is at offset 0x72. The window goes to DRAM when (smm_i is high and bit 3 is set) or when bit 6 is set. Otherwise it goes to PCI, and writes there are never blocked.
- R8: Addresses below 0xA0000 raise none of the three flags.
- R9: Writes to offsets other than 0x59 to 0x5F and 0x72 have no effect. Attribute bits [3:2] and [7:6] have no effect on the decode.
- R10: mem_units_o equals the RAM_MB parameter divided by 8, saturated at 255.
- R11: dram_sel_o and pci_fwd_o are never high together. wr_blocked_o is high only together with dram_sel_o on a write.
- R12: A register write on one clock edge governs the decode of the access presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the register bank |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register offset |
| cfg_wdata_i | input | 8 | Register write byte |
| smm_i | input | 1 | Processor is in system-management mode |
| acc_addr_i | input | 20 | Access physical address |
| acc_write_i | input | 1 | Access is a write (0 = read) |
| dram_sel_o | output | 1 | Access is served by DRAM |
| pci_fwd_o | output | 1 | Access is forwarded to PCI |
| wr_blocked_o | output | 1 | Write to a read-only DRAM region is dropped |
| mem_units_o | output | 8 | Installed memory size in 8 MB units |

## Verification
The bench builds the main instance with RAM_MB = 2100, so the size report has to saturate at 255. A second instance with RAM_MB = 100 shows the plain division result of 12. Every other parameter keeps its default. With those defaults the complete address space can be swept in 4 KB steps, visiting both the first and the last byte of each step, for reads and writes, under uniform attribute values, under several mixed per-segment patterns and after writes to unused offsets. A grid of window control values crossed with both SMM states covers every way the window can open.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

  typedef enum logic [1:0] {
    ATTR_PCI_A = 2'd0,
    ATTR_RO    = 2'd1,
    ATTR_PCI_B = 2'd2,
    ATTR_RW    = 2'd3
  } attr_e;

  typedef struct packed {
    logic dram;
    logic pci;
    logic wblk;
  } route_t;

  function automatic route_t attr_route(input logic [1:0] attr, input logic is_wr);
    route_t r;
    r = '0;
    unique case (attr_e'(attr))
      ATTR_RW: r.dram = 1'b1;
      ATTR_RO: begin
        r.dram = 1'b1;
        r.wblk = is_wr;
      end
      default: r.pci = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/lmd_regs.sv
module lmd_regs #(
  parameter logic [7:0] ATTR_BASE  = 8'h59,
  parameter int         ATTR_BYTES = 7,
  parameter logic [7:0] SMC_OFF    = 8'h72,
  parameter logic [7:0] SMC_RST    = 8'h02
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       cfg_we_i,
  input  logic [7:0]                 cfg_addr_i,
  input  logic [7:0]                 cfg_wdata_i,
  output logic [ATTR_BYTES-1:0][7:0] attr_o,
  output logic [7:0]                 smc_o
);

  localparam logic [7:0] ATTR_END = 8'(ATTR_BASE + 8'(ATTR_BYTES));

  logic [7:0] attr_q [ATTR_BYTES];
  logic [7:0] smc_q;

  for (genvar b = 0; b < ATTR_BYTES; b++) begin : g_attr
    localparam logic [7:0] OFF = 8'(ATTR_BASE + 8'(b));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              attr_q[b] <= 8'h00;
      else if (cfg_we_i && cfg_addr_i == OFF)   attr_q[b] <= cfg_wdata_i;
    end
    assign attr_o[b] = attr_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                smc_q <= SMC_RST;
    else if (cfg_we_i && cfg_addr_i == SMC_OFF) smc_q <= cfg_wdata_i;
  end
  assign smc_o = smc_q;

  logic unmapped_wr;
  assign unmapped_wr = cfg_we_i && cfg_addr_i != SMC_OFF &&
                       !(cfg_addr_i >= ATTR_BASE && cfg_addr_i < ATTR_END);

  // R7: control byte loads the written value
  a_r7_smc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == SMC_OFF) |=> smc_o == $past(cfg_wdata_i));

  // R9: stray offsets leave all state alone
  a_r9_stray_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_wr |=> ($stable(attr_o) && $stable(smc_o)));

endmodule

// File: rtl/lmd_seg_decode.sv
module lmd_seg_decode #(
  parameter int          ADDR_W     = 20,
  parameter int          ATTR_BYTES = 7,
  parameter int          SEG_COUNT  = 12,
  parameter int          SEG_BITS   = 14,
  parameter logic [19:0] SEG_BASE   = 20'hC0000,
  parameter int          BIOS_BITS  = 16,
  parameter logic [19:0] BIOS_BASE  = 20'hF0000
) (
  input  logic [ATTR_BYTES-1:0][7:0] attr_i,
  input  logic [ADDR_W-1:0]          addr_i,
  output logic                       hit_o,
  output logic [1:0]                 attr_o
);

  localparam int SEG_TAG_W  = ADDR_W - SEG_BITS;
  localparam int BIOS_TAG_W = ADDR_W - BIOS_BITS;
  localparam logic [SEG_TAG_W-1:0]  SEG_TAG0 = SEG_TAG_W'(SEG_BASE >> SEG_BITS);
  localparam logic [BIOS_TAG_W-1:0] BIOS_TAG = BIOS_TAG_W'(BIOS_BASE >> BIOS_BITS);

  logic [SEG_COUNT-1:0] seg_hit;
  logic [1:0]           seg_attr [SEG_COUNT];
  logic                 bios_hit;

  // byte 0 serves BIOS; segments share bytes 1.., low nibble even, high odd
  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_seg
    localparam int BYTE = 1 + i / 2;
    localparam int SH   = (i % 2) * 4;
    assign seg_hit[i]  = addr_i[ADDR_W-1:SEG_BITS] == SEG_TAG_W'(SEG_TAG0 + SEG_TAG_W'(i));
    assign seg_attr[i] = attr_i[BYTE][SH +: 2];
  end

  assign bios_hit = addr_i[ADDR_W-1:BIOS_BITS] == BIOS_TAG;

  always_comb begin
    hit_o  = bios_hit;
    attr_o = bios_hit ? attr_i[0][5:4] : 2'd0;
    for (int i = 0; i < SEG_COUNT; i++) begin
      if (seg_hit[i]) begin
        hit_o  = 1'b1;
        attr_o = seg_attr[i];
      end
    end
  end

endmodule

// File: rtl/lmd_smram_decode.sv
module lmd_smram_decode #(
  parameter int          ADDR_W    = 20,
  parameter int          WIN_BITS  = 17,
  parameter logic [19:0] WIN_BASE  = 20'hA0000,
  parameter int          EN_BIT    = 3,
  parameter int          FORCE_BIT = 6
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        smc_i,
  input  logic              smm_i,
  output logic              hit_o,
  output logic              open_o
);

  localparam int TAG_W = ADDR_W - WIN_BITS;
  localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(WIN_BASE >> WIN_BITS);

  assign hit_o  = addr_i[ADDR_W-1:WIN_BITS] == WIN_TAG;
  assign open_o = (smm_i && smc_i[EN_BIT]) || smc_i[FORCE_BIT];

endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
  import lmd_pkg::*;
#(
  parameter int RAM_MB = 128
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cfg_we_i,
  input  logic [7:0]  cfg_addr_i,
  input  logic [7:0]  cfg_wdata_i,
  input  logic        smm_i,
  input  logic [19:0] acc_addr_i,
  input  logic        acc_write_i,
  output logic        dram_sel_o,
  output logic        pci_fwd_o,
  output logic        wr_blocked_o,
  output logic [7:0]  mem_units_o
);

  localparam int ADDR_W     = 20;
  localparam int ATTR_BYTES = 7;
  localparam int UNITS      = RAM_MB / 8;
  localparam logic [7:0] UNITS_SAT = (UNITS > 255) ? 8'd255 : 8'(UNITS);

  logic [ATTR_BYTES-1:0][7:0] attr;
  logic [7:0]                 smc;
  logic                       seg_hit, win_hit, win_open;
  logic [1:0]                 seg_attr;
  route_t                     rt;

  lmd_regs #(
    .ATTR_BASE (8'h59),
    .ATTR_BYTES(ATTR_BYTES),
    .SMC_OFF   (8'h72),
    .SMC_RST   (8'h02)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_addr_i (cfg_addr_i),
    .cfg_wdata_i(cfg_wdata_i),
    .attr_o     (attr),
    .smc_o      (smc)
  );

  lmd_seg_decode #(
    .ADDR_W    (ADDR_W),
    .ATTR_BYTES(ATTR_BYTES)
  ) u_seg (
    .attr_i(attr),
    .addr_i(acc_addr_i),
    .hit_o (seg_hit),
    .attr_o(seg_attr)
  );

  lmd_smram_decode #(
    .ADDR_W(ADDR_W)
  ) u_win (
    .addr_i(acc_addr_i),
    .smc_i (smc),
    .smm_i (smm_i),
    .hit_o (win_hit),
    .open_o(win_open)
  );

  always_comb begin
    rt = '0;
    if (seg_hit) begin
      rt = attr_route(seg_attr, acc_write_i);
    end else if (win_hit) begin
      rt.dram = win_open;
      rt.pci  = !win_open;
    end
  end

  assign dram_sel_o   = rt.dram;
  assign pci_fwd_o    = rt.pci;
  assign wr_blocked_o = rt.wblk;
  assign mem_units_o  = UNITS_SAT;

  a_r11_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dram_sel_o && pci_fwd_o));

  a_r11_block_on_dram_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_blocked_o |-> (dram_sel_o && acc_write_i));

  a_r8_low_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_addr_i < 20'hA0000) |-> !(dram_sel_o || pci_fwd_o || wr_blocked_o));

  a_r7_window_no_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_addr_i[19:17] == 3'b101) |-> (!wr_blocked_o && (dram_sel_o != pci_fwd_o)));

endmodule

// File: tb/legacy_mem_decoder_tb_top.sv
module legacy_mem_decoder_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        smm = 1'b0;
  logic [19:0] acc_addr = '0;
  logic        acc_wr = 1'b0;
  logic        dram, pci, wblk;
  logic [7:0]  units, units_small;
  logic        d2, p2, b2;

  int checks = 0;
  int errors = 0;
  logic [7:0] mir [256];

  always #4 clk = ~clk;

  legacy_mem_decoder #(.RAM_MB(2100)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .smm_i(smm), .acc_addr_i(acc_addr),
    .acc_write_i(acc_wr), .dram_sel_o(dram), .pci_fwd_o(pci),
    .wr_blocked_o(wblk), .mem_units_o(units)
  );

  legacy_mem_decoder #(.RAM_MB(100)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(1'b0), .cfg_addr_i(8'h00),
    .cfg_wdata_i(8'h00), .smm_i(1'b0), .acc_addr_i(20'h0),
    .acc_write_i(1'b0), .dram_sel_o(d2), .pci_fwd_o(p2),
    .wr_blocked_o(b2), .mem_units_o(units_small)
  );

  function automatic logic [2:0] model(input logic [19:0] a, input logic w, input logic s);
    int i;
    logic [1:0] at;
    logic op;
    if (a >= 20'hC0000) begin
      if (a >= 20'hF0000) at = mir[8'h59][5:4];
      else begin
        i = (int'(a) - 'hC0000) >> 14;
        at = 2'((mir[8'h5A + 8'(i / 2)] >> ((i % 2) * 4)) & 8'h3);
      end
      if (at == 2'd3) return 3'b100;
      if (at == 2'd1) return {1'b1, 1'b0, w};
      return 3'b010;
    end
    if (a >= 20'hA0000) begin
      op = (s && mir[8'h72][3]) || mir[8'h72][6];
      return {op, !op, 1'b0};
    end
    return 3'b000;
  endfunction

  function automatic string tag_of(input logic [19:0] a);
    if (a >= 20'hF0000) return "R2/R4/R5/R6";
    if (a >= 20'hC0000) return "R3/R4/R5/R6";
    if (a >= 20'hA0000) return "R7";
    return "R8";
  endfunction

  task automatic cfg_write(input logic [7:0] off, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = off; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    if ((off >= 8'h59 && off <= 8'h5F) || off == 8'h72) mir[off] = val;
  endtask

  // R12: inputs driven at negedge right after a write, compared before next edge
  task automatic probe(input logic [19:0] a, input logic w, input logic s, input string extra);
    logic [2:0] exp;
    acc_addr = a; acc_wr = w; smm = s;
    #2;
    exp = model(a, w, s);
    checks++;
    if ({dram, pci, wblk} !== exp) begin
      errors++;
      $display("FAIL %s%s addr=%h wr=%0b smm=%0b got dram/pci/blk=%b exp=%b",
               tag_of(a), extra, a, w, s, {dram, pci, wblk}, exp);
    end
    checks++;
    if ((dram && pci) || (wblk && !(dram && w))) begin
      errors++;
      $display("FAIL R11 addr=%h got %b exp exclusive flags", a, {dram, pci, wblk});
    end
    @(negedge clk);
  endtask

  task automatic sweep(input string extra);
    for (int k = 0; k < 256; k++) begin
      for (int e = 0; e < 2; e++) begin
        for (int w = 0; w < 2; w++) begin
          probe(20'(k * 'h1000 + e * 'hFFF), 1'(w), 1'b0, extra);
        end
      end
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < 256; k++) mir[k] = 8'h00;
    mir[8'h72] = 8'h02;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: reset state
    sweep(" R1");
    probe(20'hA0000, 1'b0, 1'b1, " R1");

    // R10: size report
    checks++;
    if (units !== 8'd255) begin
      errors++; $display("FAIL R10 units got %0d exp 255", units);
    end
    checks++;
    if (units_small !== 8'd12) begin
      errors++; $display("FAIL R10 units got %0d exp 12", units_small);
    end

    // R4 R5 R6 R9: uniform attributes with junk in unused bits
    for (int v = 0; v < 4; v++) begin
      for (int b = 0; b < 7; b++) cfg_write(8'(8'h59 + b), 8'hCC | 8'(v) | 8'(v << 4));
      sweep(" R9");
    end

    // R2 R3: mixed per-segment patterns
    for (int s = 0; s < 4; s++) begin
      for (int b = 0; b < 7; b++) cfg_write(8'(8'h59 + b), 8'(b * 37 + s * 91 + 8'h5B));
      sweep("");
    end

    // R9: unmapped offsets ignored
    cfg_write(8'h58, 8'hFF); cfg_write(8'h60, 8'hFF);
    cfg_write(8'h71, 8'hFF); cfg_write(8'h73, 8'hFF);
    cfg_write(8'h57, 8'hFF);
    sweep(" R9");

    // R7: window control grid
    begin
      logic [7:0] grid [6] = '{8'h02, 8'h08, 8'h40, 8'h48, 8'h0A, 8'hB7};
      for (int g = 0; g < 6; g++) begin
        cfg_write(8'h72, grid[g]);
        for (int s = 0; s < 2; s++) begin
          for (int w = 0; w < 2; w++) begin
            probe(20'hA0000, 1'(w), 1'(s), "");
            probe(20'hAFFFF, 1'(w), 1'(s), "");
            probe(20'hBFFFF, 1'(w), 1'(s), "");
            probe(20'h9FFFF, 1'(w), 1'(s), "");
            probe(20'hC0000, 1'(w), 1'(s), "");
          end
        end
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule